// File: doc/BRIEF.md
# Reorder Buffer with Rollback Walk

This block keeps renamed instructions in program order from dispatch until graduation. It is a circular queue. Each slot records five things for one instruction: whether the instruction writes a register, its destination architectural register, the physical tag the rename map held for that register before this instruction, the tag newly allocated to it, and a completed flag. Dispatch writes the slot at the tail and returns the slot index. The execution side later marks that index completed. The head retires once its completed flag is set. If the head instruction wrote a register, retiring it hands the old physical tag back to the free-tag pool.

A misprediction or exception can be reported against any slot still in flight, including one that is not at the head. This lets a branch be repaired before it graduates. The buffer then unwinds from the tail toward the faulting slot, taking back one younger instruction per cycle, youngest first. For each undone instruction that has a destination, the buffer does two things. It drives the pair (architectural register, old tag) onto a map-restore port, and it returns the instruction's own allocated tag to the free pool. While the unwind runs, a busy output is high. During that time dispatch and retirement are held off, and further fault reports are not taken.

Top module: `rob_unwind`

## Requirements
- R1: An accepted dispatch is written into the slot shown on `disp_idx`. `disp_idx` then moves to the next slot, modulo DEPTH.
- R2: `disp_ready` is low when all DEPTH slots are occupied, when `busy` is high, or when `flush_valid` is high. A `disp_valid` pulse while `disp_ready` is low changes nothing.
- R3: Only the head slot retires, and only once its completed flag is set. At most one slot retires per cycle, and `ret_valid` pulses in the cycle that it does. Completing a younger slot first does not cause a retirement.
- R4: On retirement, `ret_free_valid` is high and `ret_free_tag` carries the slot's old tag, only when the slot has a destination.
- R5: A fault on slot F undoes every slot younger than F. Undoing starts with the youngest slot and proceeds one slot per cycle, beginning in the cycle after the report.
- R6: During the unwind, `rest_valid` is high, with `rest_areg`/`rest_tag` equal to the slot's destination register and old tag, only for slots that have a destination. Slots without a destination are stepped over without a restore.
- R7: During the unwind, `undo_free_valid`/`undo_free_tag` return each undone slot's newly allocated tag, only for slots that have a destination.
- R8: `busy` is high from the cycle after a fault report until the cycle in which the slot just after F is undone. It does not rise at all if F is the youngest slot.
- R9: A fault report is ignored while `busy` is high. No retirement happens while `busy` is high.
- R10: After the unwind, `disp_idx` equals F+1 modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_areg | input | 5 | Destination architectural register |
| disp_new_tag | input | 6 | Physical tag allocated to the instruction |
| disp_old_tag | input | 6 | Physical tag previously mapped to the register |
| disp_idx | output | $clog2(DEPTH) | Slot given to the next dispatch (tail) |
| cmpl_valid | input | 1 | Mark a slot completed |
| cmpl_idx | input | $clog2(DEPTH) | Slot to mark completed |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_free_valid | output | 1 | Old tag released by retirement |
| ret_free_tag | output | 6 | Released old tag |
| flush_valid | input | 1 | Fault report |
| flush_idx | input | $clog2(DEPTH) | Faulting slot |
| busy | output | 1 | Unwind in progress |
| rest_valid | output | 1 | Map restore write |
| rest_areg | output | 5 | Architectural register to restore |
| rest_tag | output | 6 | Tag written back into the map |
| undo_free_valid | output | 1 | Undone slot's tag returned to the free pool |
| undo_free_tag | output | 6 | Returned tag |

## Verification
The bound checker checks the following on every cycle:
- dispatch is blocked while busy;
- restores and undo releases occur only while busy;
- retirement never overlaps an unwind;
- a retire release never appears without a retirement;
- the tail advances by one per accepted dispatch;
- the tail retreats by one per unwind cycle.

Only the bench scenarios can show the following:
- the exact youngest-first order of restored pairs and released tags;
- that slots without a destination are stepped over;
- that the tail lands at the slot after the fault, including a wrap-around unwind from a full buffer;
- that a second report during an unwind is dropped;
- that out-of-order completion still retires in program order.

// File: rtl/rob_unwind_pkg.sv
package rob_unwind_pkg;

    localparam int AREG_W = 5;
    localparam int TAG_W  = 6;

    typedef struct packed {
        logic              has_dst;
        logic [AREG_W-1:0] areg;
        logic [TAG_W-1:0]  old_tag;
        logic [TAG_W-1:0]  new_tag;
        logic              done;
    } rob_slot_t;

endpackage

// File: rtl/rob_slot_store.sv
module rob_slot_store
    import rob_unwind_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  rob_slot_t         wr_slot,
    input  logic              done_en,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic [IDX_W-1:0]  hd_idx,
    output logic              hd_done,
    output logic              hd_has_dst,
    output logic [TAG_W-1:0]  hd_old_tag,
    input  logic [IDX_W-1:0]  wk_idx,
    output logic              wk_has_dst,
    output logic [AREG_W-1:0] wk_areg,
    output logic [TAG_W-1:0]  wk_old_tag,
    output logic [TAG_W-1:0]  wk_new_tag
);

    typedef struct packed {
        rob_slot_t [DEPTH-1:0] slots;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.slots[wr_idx] = wr_slot;
        end
        if (done_en) begin
            st_d.slots[done_idx].done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hd_done    = st_q.slots[hd_idx].done;
    assign hd_has_dst = st_q.slots[hd_idx].has_dst;
    assign hd_old_tag = st_q.slots[hd_idx].old_tag;
    assign wk_has_dst = st_q.slots[wk_idx].has_dst;
    assign wk_areg    = st_q.slots[wk_idx].areg;
    assign wk_old_tag = st_q.slots[wk_idx].old_tag;
    assign wk_new_tag = st_q.slots[wk_idx].new_tag;

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    input  logic             head_done,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] walk_idx,
    output logic             disp_ready,
    output logic             disp_fire,
    output logic             grad_fire,
    output logic             walking
);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             walking;
        logic [IDX_W-1:0] stop;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [PTR_W-1:0] count;
    logic             full;
    logic             empty;
    logic [IDX_W-1:0] stop_new;

    always_comb begin
        count      = st_q.tail - st_q.head;
        full       = (count == PTR_W'(DEPTH));
        empty      = (count == '0);
        tail_idx   = st_q.tail[IDX_W-1:0];
        head_idx   = st_q.head[IDX_W-1:0];
        walk_idx   = tail_idx - IDX_W'(1);
        walking    = st_q.walking;
        stop_new   = flush_idx + IDX_W'(1);
        disp_ready = !full && !st_q.walking && !flush_valid;
        disp_fire  = disp_valid && disp_ready;
        grad_fire  = !empty && head_done && !st_q.walking;

        st_d = st_q;
        if (grad_fire) begin
            st_d.head = st_q.head + PTR_W'(1);
        end
        if (st_q.walking) begin
            st_d.tail = st_q.tail - PTR_W'(1);
            if (walk_idx == st_q.stop) begin
                st_d.walking = 1'b0;
            end
        end else if (flush_valid) begin
            st_d.stop    = stop_new;
            st_d.walking = (tail_idx != stop_new);
        end else if (disp_fire) begin
            st_d.tail = st_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rob_unwind.sv
module rob_unwind
    import rob_unwind_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic              disp_has_dst,
    input  logic [AREG_W-1:0] disp_areg,
    input  logic [TAG_W-1:0]  disp_new_tag,
    input  logic [TAG_W-1:0]  disp_old_tag,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    output logic              ret_valid,
    output logic              ret_free_valid,
    output logic [TAG_W-1:0]  ret_free_tag,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_idx,
    output logic              busy,
    output logic              rest_valid,
    output logic [AREG_W-1:0] rest_areg,
    output logic [TAG_W-1:0]  rest_tag,
    output logic              undo_free_valid,
    output logic [TAG_W-1:0]  undo_free_tag
);

    logic [IDX_W-1:0] head_idx, tail_idx, walk_idx;
    logic             disp_fire, grad_fire, walking;
    logic             hd_done, hd_has_dst, wk_has_dst;
    logic [TAG_W-1:0] hd_old_tag, wk_old_tag, wk_new_tag;
    rob_slot_t        wr_slot;

    always_comb begin
        wr_slot         = '0;
        wr_slot.has_dst = disp_has_dst;
        wr_slot.areg    = disp_areg;
        wr_slot.old_tag = disp_old_tag;
        wr_slot.new_tag = disp_new_tag;
        wr_slot.done    = 1'b0;
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .disp_valid  (disp_valid),
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx),
        .head_done   (hd_done),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .walk_idx    (walk_idx),
        .disp_ready  (disp_ready),
        .disp_fire   (disp_fire),
        .grad_fire   (grad_fire),
        .walking     (walking)
    );

    rob_slot_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (disp_fire),
        .wr_idx     (tail_idx),
        .wr_slot    (wr_slot),
        .done_en    (cmpl_valid),
        .done_idx   (cmpl_idx),
        .hd_idx     (head_idx),
        .hd_done    (hd_done),
        .hd_has_dst (hd_has_dst),
        .hd_old_tag (hd_old_tag),
        .wk_idx     (walk_idx),
        .wk_has_dst (wk_has_dst),
        .wk_areg    (rest_areg),
        .wk_old_tag (wk_old_tag),
        .wk_new_tag (wk_new_tag)
    );

    assign disp_idx        = tail_idx;
    assign ret_valid       = grad_fire;
    assign ret_free_valid  = grad_fire && hd_has_dst;
    assign ret_free_tag    = hd_old_tag;
    assign busy            = walking;
    assign rest_valid      = walking && wk_has_dst;
    assign rest_tag        = wk_old_tag;
    assign undo_free_valid = walking && wk_has_dst;
    assign undo_free_tag   = wk_new_tag;

endmodule

// File: rtl/rob_unwind_chk.sv
module rob_unwind_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_idx,
    input logic             ret_valid,
    input logic             ret_free_valid,
    input logic             busy,
    input logic             rest_valid,
    input logic             undo_free_valid
);

    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !disp_ready); // R2

    AST_DISP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (disp_idx == IDX_W'($past(disp_idx) + IDX_W'(1)))); // R1

    AST_TAIL_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (disp_idx == IDX_W'($past(disp_idx) - IDX_W'(1)))); // R5

    AST_RESTORE_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |-> busy); // R6

    AST_UNDO_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        undo_free_valid |-> busy); // R7

    AST_NO_RETIRE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ret_valid); // R9

    AST_FREE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_free_valid |-> ret_valid); // R4

endmodule

bind rob_unwind rob_unwind_chk #(.DEPTH(DEPTH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .disp_valid      (disp_valid),
    .disp_ready      (disp_ready),
    .disp_idx        (disp_idx),
    .ret_valid       (ret_valid),
    .ret_free_valid  (ret_free_valid),
    .busy            (busy),
    .rest_valid      (rest_valid),
    .undo_free_valid (undo_free_valid)
);

// File: tb/rob_unwind_tb_top.sv
`timescale 1ns/1ps
module rob_unwind_tb_top;

    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0, disp_ready, disp_has_dst = 1'b0;
    logic [4:0] disp_areg = '0;
    logic [5:0] disp_new_tag = '0, disp_old_tag = '0;
    logic [IDX_W-1:0] disp_idx;
    logic       cmpl_valid = 1'b0;
    logic [IDX_W-1:0] cmpl_idx = '0;
    logic       ret_valid, ret_free_valid;
    logic [5:0] ret_free_tag;
    logic       flush_valid = 1'b0;
    logic [IDX_W-1:0] flush_idx = '0;
    logic       busy, rest_valid, undo_free_valid;
    logic [4:0] rest_areg;
    logic [5:0] rest_tag, undo_free_tag;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rob_unwind #(.DEPTH(DEPTH)) dut_i (.*);

    // {has_dst, areg[4:0], new_tag[5:0], old_tag[5:0]}
    localparam logic [17:0] DISP_TAB [5] = '{
        {1'b1, 5'd3, 6'd10, 6'd3},
        {1'b1, 5'd5, 6'd11, 6'd5},
        {1'b0, 5'd0, 6'd12, 6'd0},
        {1'b1, 5'd3, 6'd13, 6'd10},
        {1'b1, 5'd7, 6'd14, 6'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic put(input logic h, input int a, input int nt, input int ot);
        disp_valid   = 1'b1;
        disp_has_dst = h;
        disp_areg    = 5'(a);
        disp_new_tag = 6'(nt);
        disp_old_tag = 6'(ot);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        tick();
        rst_n = 1'b1;
        #0.1;
        // reset state
        chk("R2 reset ready", int'(disp_ready), 1);
        chk("R8 reset busy", int'(busy), 0);
        chk("R3 reset retire", int'(ret_valid), 0);
        chk("R1 reset idx", int'(disp_idx), 0);

        // table-driven dispatch
        for (int i = 0; i < 5; i++) begin
            chk("R1 slot index", int'(disp_idx), i);
            put(DISP_TAB[i][17], int'(DISP_TAB[i][16:12]), int'(DISP_TAB[i][11:6]),
                int'(DISP_TAB[i][5:0]));
            tick();
        end
        disp_valid = 1'b0;
        chk("R1 after table", int'(disp_idx), 5);

        // out-of-order completion, in-order retirement
        cmpl_valid = 1'b1; cmpl_idx = 3'd1;
        tick();
        cmpl_valid = 1'b0;
        chk("R3 younger done no retire", int'(ret_valid), 0);
        cmpl_valid = 1'b1; cmpl_idx = 3'd0;
        tick();
        cmpl_valid = 1'b0;
        chk("R3 head retires", int'(ret_valid), 1);
        chk("R4 release valid", int'(ret_free_valid), 1);
        chk("R4 release tag", int'(ret_free_tag), 3);
        tick();
        chk("R3 second retire", int'(ret_valid), 1);
        chk("R4 second tag", int'(ret_free_tag), 5);
        tick();
        chk("R3 head not done", int'(ret_valid), 0);

        // fault at slot 2, slots 4 then 3 undone
        flush_valid = 1'b1; flush_idx = 3'd2;
        #0.1;
        chk("R2 ready low on fault", int'(disp_ready), 0);
        tick();
        flush_idx = 3'd0; // second report must be dropped
        chk("R8 busy rises", int'(busy), 1);
        chk("R5 first undo areg", int'(rest_areg), 7);
        chk("R6 first restore tag", int'(rest_tag), 7);
        chk("R7 first undo tag", int'(undo_free_tag), 14);
        chk("R2 ready low busy", int'(disp_ready), 0);
        tick();
        flush_valid = 1'b0;
        chk("R5 second undo areg", int'(rest_areg), 3);
        chk("R6 second restore tag", int'(rest_tag), 10);
        chk("R7 second undo tag", int'(undo_free_tag), 13);
        chk("R9 no retire in walk", int'(ret_valid), 0);
        tick();
        chk("R8 busy falls", int'(busy), 0);
        chk("R10 tail after walk", int'(disp_idx), 3);
        chk("R9 second report ignored", int'(disp_ready), 1);

        // fault at youngest slot: no walk
        flush_valid = 1'b1; flush_idx = 3'd2;
        tick();
        flush_valid = 1'b0;
        chk("R8 no walk youngest", int'(busy), 0);
        chk("R10 tail unchanged", int'(disp_idx), 3);

        // fill to full (head = 2)
        for (int k = 0; k < 7; k++) begin
            put(1'b1, k, 40 + k, 20 + k);
            tick();
        end
        disp_valid = 1'b0;
        chk("R2 full blocks", int'(disp_ready), 0);
        chk("R1 full tail", int'(disp_idx), 2);
        put(1'b1, 31, 63, 63);
        tick();
        disp_valid = 1'b0;
        chk("R2 blocked dispatch ignored", int'(disp_idx), 2);

        // fault at head with full buffer: wrap-around walk of 7 slots
        flush_valid = 1'b1; flush_idx = 3'd2;
        tick();
        flush_valid = 1'b0;
        for (int k = 6; k >= 0; k--) begin
            chk("R8 busy in long walk", int'(busy), 1);
            chk("R5 long walk areg", int'(rest_areg), k);
            chk("R6 long walk tag", int'(rest_tag), 20 + k);
            chk("R7 long walk free", int'(undo_free_tag), 40 + k);
            tick();
        end
        chk("R8 long walk done", int'(busy), 0);
        chk("R10 tail after wrap", int'(disp_idx), 3);

        // no-destination slot at head retires without release
        cmpl_valid = 1'b1; cmpl_idx = 3'd2;
        tick();
        cmpl_valid = 1'b0;
        chk("R3 no-dst retires", int'(ret_valid), 1);
        chk("R4 no-dst no release", int'(ret_free_valid), 0);
        tick();
        chk("R3 empty no retire", int'(ret_valid), 0);

        // walk across a slot without destination
        put(1'b1, 1, 50, 2);  tick();
        put(1'b0, 0, 0, 0);   tick();
        put(1'b1, 9, 31, 30); tick();
        disp_valid = 1'b0;
        flush_valid = 1'b1; flush_idx = 3'd3;
        tick();
        flush_valid = 1'b0;
        chk("R6 dst slot restore", int'(rest_valid), 1);
        chk("R6 dst slot tag", int'(rest_tag), 30);
        tick();
        chk("R8 busy on no-dst slot", int'(busy), 1);
        chk("R6 no-dst skipped", int'(rest_valid), 0);
        chk("R7 no-dst no free", int'(undo_free_valid), 0);
        tick();
        chk("R8 busy done", int'(busy), 0);
        chk("R10 tail at F+1", int'(disp_idx), 4);

        finish_run();
    end

endmodule